// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies gamma correction to the pixel streams of a display scaler that drives several output channels. Every channel owns a separate 24-bit pixel stream with an 8-bit red, green and blue component. When a channel's gamma enable is high, each component is replaced by an entry from a correction table. When the enable is low, the pixel passes through unchanged. Both paths have the same latency, so a channel can switch modes without breaking the alignment of its pixels.

All channels share one packed table memory. Software loads it through two registers. An address register holds the table pointer, an auto-advance flag and a force-power flag. Each access to the data register stores or fetches one entry at the pointer. When auto-advance is on, a full channel of 768 entries loads as a plain stream of data writes. The table memory is powered only while some channel uses it or the force-power flag is set. Powering it down destroys the contents, so the table must be loaded again afterwards.

Top module: `gamma_lut_top`

## Requirements
- R1: The table entry for channel c, component k (red k=0, green k=1, blue k=2) and input value v is at pointer c*768 + k*256 + v. Each entry is 8 bits. With the default of three channels the table holds 2304 entries.
- R2: The address register is at byte offset 0x78. Its fields are pointer in bits 11:0, force-power in bit 30 and auto-advance in bit 31. The same layout reads back, with the other bits zero. All fields are zero after reset.
- R3: A write to the data register (offset 0xE0) stores bits 7:0 of the write data at the pointer. When auto-advance is set, each data write and each data read moves the pointer up by one. When auto-advance is clear, the pointer does not move.
- R4: When auto-advance moves the pointer past entry 2303, the pointer wraps to 0.
- R5: A register read returns its data on reg_rdata one cycle later, with reg_rvalid high in that cycle. A data-register read returns the entry in bits 7:0 and zeros in all other bits.
- R6: For a channel whose gamma enable is high when a pixel enters, the output pixel appears two cycles later. Each component of that output is the table entry for its channel, component and value.
- R7: For a channel whose gamma enable is low when a pixel enters, the pixel appears unchanged two cycles later. Output valid always repeats input valid two cycles later.
- R8: sram_on is high exactly when the force-power bit is set or at least one channel's gamma enable is high.
- R9: While sram_on is low, data writes are dropped and data reads return zero. After any cycle with sram_on low, every entry reads and looks up as zero until it is written again. Entries never written since reset also read as zero.
- R10: A data write to a pointer above 2303 is dropped. A data read at such a pointer returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ch_gamma_en | input | NUM_CH | Per-channel gamma enable |
| pix_in_valid | input | NUM_CH | Per-channel input pixel valid |
| pix_in_data | input | NUM_CH*24 | Input pixels; channel c at bits c*24 upward, red in the top byte, blue in the bottom byte |
| pix_out_valid | output | NUM_CH | Per-channel output pixel valid |
| pix_out_data | output | NUM_CH*24 | Output pixels, same packing as the input |
| sram_on | output | 1 | Table memory powered |

## Verification
Channel 0 is loaded with three different tables: an inverting ramp for red, an XOR pattern for green and a times-three ramp for blue. A swap of component blocks or a wrong base offset then shows up as a wrong value. In the same stream, channel 1 runs with gamma disabled and a gapped valid pattern, which separates the bypass path and valid alignment from the corrected path. Channel 2 uses a few single entries written without auto-advance, which checks the channel base address. The pointer is tested at wrap-around, past the table end, with auto-advance off and with data reads. A power-down sequence then shows that dropped writes, zero reads and lost contents all behave as required.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

    localparam int COMP_W           = 8;
    localparam int NUM_COMP         = 3;
    localparam int ENTRIES_PER_COMP = 1 << COMP_W;
    localparam int PIX_W            = COMP_W * NUM_COMP;
    localparam int REG_W            = 32;

    localparam logic [7:0] OFS_PTR_REG  = 8'h78;
    localparam logic [7:0] OFS_DATA_REG = 8'hE0;
    localparam int         BIT_AUTOINC  = 31;
    localparam int         BIT_FORCE    = 30;

    typedef logic [COMP_W-1:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } pixel_t;

    typedef enum logic [1:0] {
        COMP_R = 2'd0,
        COMP_G = 2'd1,
        COMP_B = 2'd2
    } comp_sel_e;

    typedef struct packed {
        logic   valid;
        logic   en;
        pixel_t pix;
    } stage_t;

    // Linear table index of one component value of one channel
    function automatic int unsigned lut_index(int unsigned ch, comp_sel_e sel, comp_t v);
        return ch * NUM_COMP * ENTRIES_PER_COMP
             + int'(unsigned'(sel)) * ENTRIES_PER_COMP
             + int'(unsigned'(v));
    endfunction

endpackage

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12,
    parameter int NRD    = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         power,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  comp_t                        wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][COMP_W-1:0]   rdata
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    comp_t            store_q [DEPTH];
    logic [DEPTH-1:0] live_q;

    logic wr_ok;
    assign wr_ok = we && power && (waddr <= LAST);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store_q[waddr] <= wdata;
        end
    end

    // Contents are treated as lost whenever power drops
    always_ff @(posedge clk) begin
        if (rst || !power) begin
            live_q <= '0;
        end else if (wr_ok) begin
            live_q[waddr] <= 1'b1;
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        always_comb begin
            if (power && (raddr[i] <= LAST) && live_q[raddr[i]]) begin
                rdata[i] = store_q[raddr[i]];
            end else begin
                rdata[i] = '0;
            end
        end
    end

endmodule

// File: rtl/gamma_regif.sv
module gamma_regif
    import gamma_lut_pkg::*;
#(
    parameter int DEPTH  = 2304,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  comp_t             mem_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              autoinc,
    output logic              force_on,
    output logic              mem_we,
    output comp_t             mem_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q, ptr_inc;
    logic              autoinc_q, force_q;
    logic              rd_go, ptr_wr, data_wr, data_rd, ptr_rd;

    assign rd_go   = reg_rd && !reg_wr;
    assign ptr_wr  = reg_wr && (reg_addr == OFS_PTR_REG);
    assign data_wr = reg_wr && (reg_addr == OFS_DATA_REG);
    assign data_rd = rd_go  && (reg_addr == OFS_DATA_REG);
    assign ptr_rd  = rd_go  && (reg_addr == OFS_PTR_REG);
    assign ptr_inc = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;

    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[BIT_FORCE-1:ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            autoinc_q  <= 1'b0;
            force_q    <= 1'b0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= rd_go;
            if (ptr_wr) begin
                ptr_q     <= reg_wdata[ADDR_W-1:0];
                autoinc_q <= reg_wdata[BIT_AUTOINC];
                force_q   <= reg_wdata[BIT_FORCE];
            end else if ((data_wr || data_rd) && autoinc_q) begin
                ptr_q <= ptr_inc;
            end
            if (data_rd) begin
                reg_rdata <= {{(REG_W-COMP_W){1'b0}}, mem_rdata};
            end else if (ptr_rd) begin
                reg_rdata <= {autoinc_q, force_q, {(REG_W-2-ADDR_W){1'b0}}, ptr_q};
            end else if (rd_go) begin
                reg_rdata <= '0;
            end
        end
    end

    assign ptr       = ptr_q;
    assign autoinc   = autoinc_q;
    assign force_on  = force_q;
    assign mem_we    = data_wr;
    assign mem_wdata = reg_wdata[COMP_W-1:0];

endmodule

// File: rtl/gamma_pix_pipe.sv
module gamma_pix_pipe
    import gamma_lut_pkg::*;
#(
    parameter int CH_IDX = 0,
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  pixel_t                            in_pix,
    input  logic                              en,
    output logic [NUM_COMP-1:0][ADDR_W-1:0]   lut_addr,
    input  logic [NUM_COMP-1:0][COMP_W-1:0]   lut_data,
    output logic                              out_valid,
    output pixel_t                            out_pix
);

    stage_t s1_q;
    pixel_t fixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            s1_q.en    <= en;
            s1_q.pix   <= in_pix;
        end
    end

    assign lut_addr[0] = ADDR_W'(lut_index(CH_IDX, COMP_R, s1_q.pix.r));
    assign lut_addr[1] = ADDR_W'(lut_index(CH_IDX, COMP_G, s1_q.pix.g));
    assign lut_addr[2] = ADDR_W'(lut_index(CH_IDX, COMP_B, s1_q.pix.b));

    assign fixed.r = lut_data[0];
    assign fixed.g = lut_data[1];
    assign fixed.b = lut_data[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_q.valid;
            out_pix   <= s1_q.en ? fixed : s1_q.pix;
        end
    end

endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [7:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    reg_rvalid,
    input  logic [NUM_CH-1:0]       ch_gamma_en,
    input  logic [NUM_CH-1:0]       pix_in_valid,
    input  logic [NUM_CH*24-1:0]    pix_in_data,
    output logic [NUM_CH-1:0]       pix_out_valid,
    output logic [NUM_CH*24-1:0]    pix_out_data,
    output logic                    sram_on
);

    localparam int DEPTH = NUM_CH * NUM_COMP * ENTRIES_PER_COMP;
    localparam int NRD   = NUM_CH * NUM_COMP + 1;

    logic [ADDR_W-1:0]            ptr;
    logic                         autoinc, force_on, mem_we;
    comp_t                        mem_wdata;
    logic [NRD-1:0][ADDR_W-1:0]   rd_addr;
    logic [NRD-1:0][COMP_W-1:0]   rd_data;

    assign sram_on = force_on || (|ch_gamma_en);

    gamma_regif #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mem_rdata (rd_data[0]),
        .ptr       (ptr),
        .autoinc   (autoinc),
        .force_on  (force_on),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid)
    );

    assign rd_addr[0] = ptr;

    gamma_lut_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NRD(NRD)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .power (sram_on),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pixel_t out_pix;

        gamma_pix_pipe #(.CH_IDX(c), .ADDR_W(ADDR_W)) u_pipe (
            .clk      (clk),
            .rst      (rst),
            .in_valid (pix_in_valid[c]),
            .in_pix   (pixel_t'(pix_in_data[c*PIX_W +: PIX_W])),
            .en       (ch_gamma_en[c]),
            .lut_addr (rd_addr[1 + c*NUM_COMP +: NUM_COMP]),
            .lut_data (rd_data[1 + c*NUM_COMP +: NUM_COMP]),
            .out_valid(pix_out_valid[c]),
            .out_pix  (out_pix)
        );

        assign pix_out_data[c*PIX_W +: PIX_W] = out_pix;
    end

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [7:0]           reg_addr,
    input logic [31:0]          reg_rdata,
    input logic                 reg_rvalid,
    input logic [NUM_CH-1:0]    ch_gamma_en,
    input logic [NUM_CH-1:0]    pix_in_valid,
    input logic [NUM_CH*24-1:0] pix_in_data,
    input logic [NUM_CH-1:0]    pix_out_valid,
    input logic [NUM_CH*24-1:0] pix_out_data,
    input logic                 sram_on,
    input logic [ADDR_W-1:0]    ptr,
    input logic                 autoinc
);

    localparam int                DEPTH = NUM_CH * NUM_COMP * ENTRIES_PER_COMP;
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(DEPTH - 1);

    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R5
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr) |=> reg_rvalid);

    // R3
    autoinc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_DATA_REG && autoinc && ptr < LAST)
        |=> ptr == $past(ptr) + 1'b1);

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_DATA_REG && autoinc && ptr == LAST)
        |=> ptr == '0);

    // R9
    off_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == OFS_DATA_REG && !sram_on)
        |=> reg_rdata == '0);

    // R7
    valid_align_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> pix_out_valid == $past(pix_in_valid, 2));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bypass
        // R7
        bypass_chk: assert property (@(posedge clk) disable iff (rst)
            (age_q >= 2'd2 && pix_out_valid[c] && !$past(ch_gamma_en[c], 2))
            |-> pix_out_data[c*PIX_W +: PIX_W] == $past(pix_in_data[c*PIX_W +: PIX_W], 2));
    end

endmodule

bind gamma_lut_top gamma_lut_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid),
    .ch_gamma_en  (ch_gamma_en),
    .pix_in_valid (pix_in_valid),
    .pix_in_data  (pix_in_data),
    .pix_out_valid(pix_out_valid),
    .pix_out_data (pix_out_data),
    .sram_on      (sram_on),
    .ptr          (ptr),
    .autoinc      (autoinc)
);

// File: tb/tb_gamma_lut_top.sv
module tb_gamma_lut_top;

    localparam int NUM_CH = 3;
    localparam logic [7:0] A_PTR  = 8'h78;
    localparam logic [7:0] A_DATA = 8'hE0;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 reg_wr, reg_rd;
    logic [7:0]           reg_addr;
    logic [31:0]          reg_wdata;
    logic [31:0]          reg_rdata;
    logic                 reg_rvalid;
    logic [NUM_CH-1:0]    ch_gamma_en;
    logic [NUM_CH-1:0]    pix_in_valid;
    logic [NUM_CH*24-1:0] pix_in_data;
    logic [NUM_CH-1:0]    pix_out_valid;
    logic [NUM_CH*24-1:0] pix_out_data;
    logic                 sram_on;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gamma_lut_top #(.NUM_CH(NUM_CH), .ADDR_W(12)) dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .ch_gamma_en(ch_gamma_en), .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data),
        .pix_out_valid(pix_out_valid), .pix_out_data(pix_out_data), .sram_on(sram_on)
    );

    function automatic logic [7:0] exp_r(logic [7:0] v); return 8'(255 - v); endfunction
    function automatic logic [7:0] exp_g(logic [7:0] v); return v ^ 8'h5A; endfunction
    function automatic logic [7:0] exp_b(logic [7:0] v); return 8'(v * 3); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        checks++;
        if (reg_rvalid !== 1'b1) begin
            errors++;
            $display("FAIL R5: rvalid actual=%b expected=1", reg_rvalid);
        end
        d = reg_rdata;
    endtask

    task automatic one_pixel(int ch, logic [23:0] p, output logic [23:0] q);
        pix_in_valid = '0;
        pix_in_valid[ch] = 1'b1;
        pix_in_data[ch*24 +: 24] = p;
        @(negedge clk);
        pix_in_valid = '0;
        @(negedge clk);
        checks++;
        if (pix_out_valid[ch] !== 1'b1) begin
            errors++;
            $display("FAIL R7: valid actual=%b expected=1", pix_out_valid[ch]);
        end
        q = pix_out_data[ch*24 +: 24];
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset sram_on", 32'(sram_on), 32'd0);
        check("R7 reset valid", 32'(pix_out_valid), 32'd0);
        rd(A_PTR, d);
        check("R2 reset ptr reg", d, 32'h0);
    endtask

    task automatic t_load_readback();
        logic [31:0] d;
        wr(A_PTR, 32'hC000_0000);
        for (int i = 0; i < 256; i++) wr(A_DATA, 32'(exp_r(8'(i))));
        for (int i = 0; i < 256; i++) wr(A_DATA, 32'(exp_g(8'(i))));
        for (int i = 0; i < 256; i++) wr(A_DATA, 32'(exp_b(8'(i))));
        check("R8 forced on", 32'(sram_on), 32'd1);
        rd(A_PTR, d);
        check("R3 ptr after 768 writes", d, 32'hC000_0300);
        wr(A_PTR, 32'hC000_0005);
        for (int i = 5; i < 8; i++) begin
            rd(A_DATA, d);
            check("R5 readback", d, 32'(exp_r(8'(i))));
        end
        rd(A_PTR, d);
        check("R3 reads advance ptr", d, 32'hC000_0008);
    endtask

    task automatic t_noinc();
        logic [31:0] d;
        wr(A_PTR, 32'h4000_030A);
        wr(A_DATA, 32'hFFFF_FF33);
        wr(A_DATA, 32'h0000_0044);
        rd(A_PTR, d);
        check("R3 no advance", d, 32'h4000_030A);
        rd(A_DATA, d);
        check("R3 last write kept", d, 32'h44);
        rd(A_DATA, d);
        check("R3 read no advance", d, 32'h44);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(A_PTR, 32'hC000_08FF);
        wr(A_DATA, 32'hA5);
        wr(A_DATA, 32'h5B);
        rd(A_PTR, d);
        check("R4 wrapped ptr", d, 32'hC000_0001);
        wr(A_PTR, 32'h4000_08FF);
        rd(A_DATA, d);
        check("R4 last entry", d, 32'hA5);
        wr(A_PTR, 32'h4000_0000);
        rd(A_DATA, d);
        check("R4 entry 0", d, 32'h5B);
        wr(A_DATA, 32'(exp_r(8'd0)));
    endtask

    task automatic t_oob();
        logic [31:0] d;
        wr(A_PTR, 32'h4000_0BB8);
        wr(A_DATA, 32'h77);
        rd(A_DATA, d);
        check("R10 beyond table", d, 32'h0);
    endtask

    task automatic t_stream();
        logic [23:0] pin [8];
        logic        vin [8];
        ch_gamma_en = 3'b001;
        for (int k = 0; k < 8; k++) begin
            pin[k] = {8'(k * 37), 8'(255 - k * 11), 8'(k * 91)};
            vin[k] = (k % 3) != 2;
        end
        for (int k = 0; k < 9; k++) begin
            if (k < 8) begin
                pix_in_valid = {1'b0, vin[k], 1'b1};
                pix_in_data  = {24'h0, pin[k], pin[k]};
            end else begin
                pix_in_valid = '0;
            end
            @(negedge clk);
            if (k >= 1) begin
                check("R6 ch0 valid", 32'(pix_out_valid[0]), 32'd1);
                check("R6 R1 ch0 lookup", 32'(pix_out_data[23:0]),
                      32'({exp_r(pin[k-1][23:16]), exp_g(pin[k-1][15:8]), exp_b(pin[k-1][7:0])}));
                check("R7 ch1 valid", 32'(pix_out_valid[1]), 32'(vin[k-1]));
                if (vin[k-1]) check("R7 ch1 bypass", 32'(pix_out_data[47:24]), 32'(pin[k-1]));
            end
        end
    endtask

    task automatic t_ch2();
        logic [23:0] q;
        wr(A_PTR, 32'h4000_0000 | 32'(2*768 + 256 + 8'h40));
        wr(A_DATA, 32'h11);
        wr(A_PTR, 32'h4000_0000 | 32'(2*768 + 8'h10));
        wr(A_DATA, 32'h22);
        wr(A_PTR, 32'h4000_0000 | 32'(2*768 + 512 + 8'h20));
        wr(A_DATA, 32'h33);
        ch_gamma_en = 3'b100;
        one_pixel(2, 24'h10_40_20, q);
        check("R1 ch2 base", 32'(q), 32'h22_11_33);
        one_pixel(2, 24'h11_41_21, q);
        check("R9 never written", 32'(q), 32'h0);
    endtask

    task automatic t_power();
        logic [31:0] d;
        logic [23:0] q;
        ch_gamma_en = 3'b000;
        wr(A_PTR, 32'h8000_0005);
        check("R8 off", 32'(sram_on), 32'd0);
        rd(A_DATA, d);
        check("R9 read while off", d, 32'h0);
        wr(A_DATA, 32'h99);
        wr(A_PTR, 32'h4000_0006);
        check("R8 force", 32'(sram_on), 32'd1);
        rd(A_DATA, d);
        check("R9 write dropped", d, 32'h0);
        wr(A_PTR, 32'h4000_0005);
        rd(A_DATA, d);
        check("R9 contents lost", d, 32'h0);
        wr(A_PTR, 32'h0000_0000);
        ch_gamma_en = 3'b001;
        #1;
        check("R8 channel enable", 32'(sram_on), 32'd1);
        one_pixel(0, 24'h05_05_05, q);
        check("R9 lookup after loss", 32'(q), 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        ch_gamma_en = '0; pix_in_valid = '0; pix_in_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_readback();
        t_noinc();
        t_wrap();
        t_oob();
        t_stream();
        t_ch2();
        t_power();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule